// File: doc/BRIEF.md
# Dual-Issue Integer/Floating-Point Issue Checker

This block sits in the decode stage of a statically scheduled, two-wide, in-order pipeline. Every cycle the fetch side presents an ordered pair of decoded instructions: an older slot A and a younger slot B. Each slot carries a valid bit, a class bit (integer or floating-point), a load flag, a write-enable with a destination register, and two source registers. The checker decides combinationally whether none, one or both slots issue in this cycle, and it flags a stall when the older instruction has to wait.

Pairing is allowed only when one slot is integer class (ALU, load/store, branch) and the other is floating-point. A per-register countdown scoreboard keeps track of results that are still in flight. An issued floating-point add blocks readers of its destination for three cycles. An issued load blocks readers of its destination for one cycle. Results of integer non-load operations are taken as forwarded and block nothing. When only slot A issues, the fetch side re-presents the instruction in slot B as next cycle's slot A. The register file, the forwarding paths and the execution units are outside this block.

Top module: `dual_issue_gate`

## Requirements
- R1: While `rst_n` is low, `iss_a`, `iss_b`, `stall` and `iss_n` are all 0, whatever the inputs. After reset every register is free.
- R2: If slot A and slot B are both valid, one has class 0 (integer) and the other class 1 (floating-point), no source is busy, and B reads no register that A writes, both issue (`iss_n`=2). Such pairs issue two per cycle in consecutive cycles.
- R3: If both valid slots have the same class, only slot A issues (`iss_n`=1, `stall`=0).
- R4: If A writes a register (`a_wr`=1) that B names as either source, only slot A issues.
- R5: Issue is in order. If slot A is blocked by a busy source, slot B does not issue either, even when B is hazard-free.
- R6: `stall` is 1 exactly when slot A is valid and not issued. When slot A is invalid, nothing issues and `stall` is 0, even if slot B is valid.
- R7: An issued floating-point instruction with `*_wr`=1 keeps its destination busy for the next three cycles. A reader in slot A stalls in those three cycles and issues in the fourth.
- R8: An issued integer load (`*_ld`=1, class 0) with `*_wr`=1 keeps its destination busy for the next one cycle only.
- R9: An issued integer non-load write leaves its destination free in the very next cycle.
- R10: If slot A is clean but a source of slot B is busy, only slot A issues.
- R11: `iss_n` always equals the number of asserted bits among `iss_a` and `iss_b`.
- R12: If both slots of an issued pair write the same register, the scoreboard takes slot B's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_vld | input | 1 | Older slot holds an instruction |
| a_fp | input | 1 | Older slot class: 0 integer, 1 floating-point |
| a_ld | input | 1 | Older slot is a load |
| a_wr | input | 1 | Older slot writes a destination |
| a_dst | input | RW | Older slot destination register |
| a_x | input | RW | Older slot first source |
| a_y | input | RW | Older slot second source |
| b_vld | input | 1 | Younger slot holds an instruction |
| b_fp | input | 1 | Younger slot class: 0 integer, 1 floating-point |
| b_ld | input | 1 | Younger slot is a load |
| b_wr | input | 1 | Younger slot writes a destination |
| b_dst | input | RW | Younger slot destination register |
| b_x | input | RW | Younger slot first source |
| b_y | input | RW | Younger slot second source |
| iss_a | output | 1 | Older slot issues this cycle |
| iss_b | output | 1 | Younger slot issues this cycle |
| iss_n | output | 2 | Number of instructions issued (0, 1 or 2) |
| stall | output | 1 | Older valid instruction is held |

## Verification
Some properties are checked by assertions in every cycle. Slot B never issues without slot A, and never with a slot of its own class. B never issues while it reads A's destination. A busy source on slot A always stalls the pair. `iss_n` matches the issue bits. Each scoreboard counter either reloads from the write that hit it or counts down by one. Other behaviour only the directed scenarios can show: the exact three-cycle and one-cycle hold windows seen at the ports, the younger-wins rule when both slots write the same register, sustained two-per-cycle issue, and the silent outputs during reset.

// File: rtl/dig_pkg.sv
package dig_pkg;

  // Cycles a freshly issued result keeps its destination busy.
  function automatic int unsigned hold_cycles(input logic is_fp, input logic is_ld,
                                              input int unsigned fp_lat,
                                              input int unsigned ld_lat);
    if (is_fp) return fp_lat;
    if (is_ld) return ld_lat;
    return 0;
  endfunction

  // Younger instruction consumes the older instruction's result.
  function automatic logic reads_result(input logic wr, input int unsigned dst,
                                        input int unsigned sx, input int unsigned sy);
    return wr && ((sx == dst) || (sy == dst));
  endfunction

endpackage

// File: rtl/dig_scoreboard.sv
module dig_scoreboard #(
  parameter int NREGS  = 64,
  parameter int MAXLAT = 3,
  parameter int NQ     = 4,
  localparam int RW    = $clog2(NREGS),
  localparam int CW    = $clog2(MAXLAT + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we0,
  input  logic [RW-1:0]         wr0,
  input  logic [CW-1:0]         lat0,
  input  logic                  we1,
  input  logic [RW-1:0]         wr1,
  input  logic [CW-1:0]         lat1,
  input  logic [NQ-1:0][RW-1:0] q,
  output logic [NQ-1:0]         busy
);

  logic [CW-1:0] cnt [NREGS];
  logic [NREGS-1:0] hit0, hit1;

  generate
    for (genvar r = 0; r < NREGS; r++) begin : g_reg
      assign hit0[r] = we0 && (wr0 == RW'(r));
      assign hit1[r] = we1 && (wr1 == RW'(r));

      // R7 R8 R9
      dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[r] != '0 && !hit0[r] && !hit1[r]) |=> (cnt[r] == $past(cnt[r]) - CW'(1)));
      idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt[r] == '0 && !hit0[r] && !hit1[r]) |=> (cnt[r] == '0));
      // R12
      young_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit1[r] |=> (cnt[r] == $past(lat1)));
    end
    for (genvar k = 0; k < NQ; k++) begin : g_q
      assign busy[k] = (cnt[q[k]] != '0);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREGS; r++) cnt[r] <= '0;
    end else begin
      for (int r = 0; r < NREGS; r++) begin
        if (hit1[r])             cnt[r] <= lat1;
        else if (hit0[r])        cnt[r] <= lat0;
        else if (cnt[r] != '0)   cnt[r] <= cnt[r] - CW'(1);
      end
    end
  end

endmodule

// File: rtl/dig_pair_rules.sv
module dig_pair_rules #(
  parameter int NREGS = 64,
  localparam int RW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_vld,
  input  logic          a_fp,
  input  logic          a_wr,
  input  logic [RW-1:0] a_dst,
  input  logic          b_vld,
  input  logic          b_fp,
  input  logic [RW-1:0] b_x,
  input  logic [RW-1:0] b_y,
  input  logic [3:0]    busy,
  output logic          iss_a,
  output logic          iss_b,
  output logic          stall
);
  import dig_pkg::*;

  logic a_raw, b_raw, b_dep, mixed;

  assign a_raw = busy[0] | busy[1];
  assign b_raw = busy[2] | busy[3];
  assign b_dep = reads_result(a_wr, int'(a_dst), int'(b_x), int'(b_y));
  assign mixed = a_fp ^ b_fp;

  always_comb begin
    iss_a = rst_n && a_vld && !a_raw;
    iss_b = iss_a && b_vld && mixed && !b_raw && !b_dep;
    stall = rst_n && a_vld && !iss_a;
  end

  // R5
  order_chk: assert property (@(posedge clk) disable iff (!rst_n) iss_b |-> iss_a);
  // R3
  mix_chk: assert property (@(posedge clk) disable iff (!rst_n) iss_b |-> (a_fp != b_fp));
  // R4
  dep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_b && a_wr) |-> (b_x != a_dst && b_y != a_dst));
  // R5
  raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld && (busy[0] || busy[1])) |-> (stall && !iss_b));

endmodule

// File: rtl/dual_issue_gate.sv
module dual_issue_gate #(
  parameter int NREGS  = 64,
  parameter int FP_LAT = 3,
  parameter int LD_LAT = 1,
  localparam int RW    = $clog2(NREGS),
  localparam int MAXLAT = (FP_LAT > LD_LAT) ? FP_LAT : LD_LAT,
  localparam int CW    = $clog2(MAXLAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_vld,
  input  logic          a_fp,
  input  logic          a_ld,
  input  logic          a_wr,
  input  logic [RW-1:0] a_dst,
  input  logic [RW-1:0] a_x,
  input  logic [RW-1:0] a_y,
  input  logic          b_vld,
  input  logic          b_fp,
  input  logic          b_ld,
  input  logic          b_wr,
  input  logic [RW-1:0] b_dst,
  input  logic [RW-1:0] b_x,
  input  logic [RW-1:0] b_y,
  output logic          iss_a,
  output logic          iss_b,
  output logic [1:0]    iss_n,
  output logic          stall
);
  import dig_pkg::*;

  logic [3:0]         busy;
  logic [3:0][RW-1:0] q;
  logic               we_a, we_b;
  logic [CW-1:0]      lat_a, lat_b;

  assign q     = {b_y, b_x, a_y, a_x};
  assign we_a  = iss_a && a_wr;
  assign we_b  = iss_b && b_wr;
  assign lat_a = CW'(hold_cycles(a_fp, a_ld, FP_LAT, LD_LAT));
  assign lat_b = CW'(hold_cycles(b_fp, b_ld, FP_LAT, LD_LAT));

  dig_scoreboard #(.NREGS(NREGS), .MAXLAT(MAXLAT), .NQ(4)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .we0(we_a), .wr0(a_dst), .lat0(lat_a),
    .we1(we_b), .wr1(b_dst), .lat1(lat_b),
    .q(q), .busy(busy)
  );

  dig_pair_rules #(.NREGS(NREGS)) u_rules (
    .clk(clk), .rst_n(rst_n),
    .a_vld(a_vld), .a_fp(a_fp), .a_wr(a_wr), .a_dst(a_dst),
    .b_vld(b_vld), .b_fp(b_fp), .b_x(b_x), .b_y(b_y),
    .busy(busy), .iss_a(iss_a), .iss_b(iss_b), .stall(stall)
  );

  assign iss_n = {iss_a & iss_b, iss_a ^ iss_b};

  // R11
  count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_n == 2'($countones({iss_a, iss_b})));

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (iss_n == 2'd0 && !stall && !iss_a && !iss_b);
    end
  end

endmodule

// File: tb/dual_issue_gate_test.sv
module dual_issue_gate_test;
  localparam int RW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_vld, a_fp, a_ld, a_wr, b_vld, b_fp, b_ld, b_wr;
  logic [RW-1:0] a_dst, a_x, a_y, b_dst, b_x, b_y;
  logic iss_a, iss_b, stall;
  logic [1:0] iss_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dual_issue_gate uut (
    .clk(clk), .rst_n(rst_n),
    .a_vld(a_vld), .a_fp(a_fp), .a_ld(a_ld), .a_wr(a_wr),
    .a_dst(a_dst), .a_x(a_x), .a_y(a_y),
    .b_vld(b_vld), .b_fp(b_fp), .b_ld(b_ld), .b_wr(b_wr),
    .b_dst(b_dst), .b_x(b_x), .b_y(b_y),
    .iss_a(iss_a), .iss_b(iss_b), .iss_n(iss_n), .stall(stall)
  );

  task automatic slot_a(input logic v, fp, ld, wr, input int d, x, y);
    a_vld = v; a_fp = fp; a_ld = ld; a_wr = wr;
    a_dst = RW'(d); a_x = RW'(x); a_y = RW'(y);
  endtask

  task automatic slot_b(input logic v, fp, ld, wr, input int d, x, y);
    b_vld = v; b_fp = fp; b_ld = ld; b_wr = wr;
    b_dst = RW'(d); b_x = RW'(x); b_y = RW'(y);
  endtask

  // Check outputs at the falling edge, then move to just after the next rising edge.
  task automatic cyc(input string req, input int en, input logic ea, eb, es);
    @(negedge clk);
    checks++;
    if (iss_n !== 2'(en) || iss_a !== ea || iss_b !== eb || stall !== es) begin
      fails++;
      $display("FAIL %s: got n=%0d a=%0b b=%0b stall=%0b, expected n=%0d a=%0b b=%0b stall=%0b",
               req, iss_n, iss_a, iss_b, stall, en, ea, eb, es);
    end
    @(posedge clk); #1;
  endtask

  task automatic drain();
    slot_a(0, 0, 0, 0, 0, 0, 0);
    slot_b(0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    slot_a(1, 0, 0, 1, 1, 2, 3);
    slot_b(1, 1, 0, 1, 40, 41, 42);
    @(negedge clk);
    checks++;
    if (iss_n !== 2'd0 || iss_a !== 1'b0 || iss_b !== 1'b0 || stall !== 1'b0) begin
      fails++;
      $display("FAIL R1: got n=%0d stall=%0b, expected n=0 stall=0", iss_n, stall);
    end
    rst_n = 1'b1;
    @(posedge clk); #1;
    cyc("R1 free after reset", 2, 1, 1, 0);
  endtask

  task automatic t_pairs();
    drain();
    for (int i = 0; i < 3; i++) begin
      slot_a(1, 0, 0, 1, 1 + i, 8, 9);
      slot_b(1, 1, 0, 0, 0, 41 + i, 42 + i);
      cyc("R2 sustained pair", 2, 1, 1, 0);
    end
    slot_a(1, 1, 0, 0, 0, 50, 51);
    slot_b(1, 0, 0, 0, 0, 52, 53);
    cyc("R2 fp older int younger", 2, 1, 1, 0);
  endtask

  task automatic t_same_class();
    drain();
    slot_a(1, 0, 0, 0, 0, 2, 3); slot_b(1, 0, 0, 0, 0, 4, 5);
    cyc("R3 int+int", 1, 1, 0, 0);
    slot_a(1, 1, 0, 0, 0, 40, 41); slot_b(1, 1, 0, 0, 0, 42, 43);
    cyc("R3 fp+fp", 1, 1, 0, 0);
  endtask

  task automatic t_dep();
    drain();
    slot_a(1, 0, 0, 1, 5, 2, 3); slot_b(1, 1, 0, 0, 0, 40, 5);
    cyc("R4 younger reads older dst", 1, 1, 0, 0);
    slot_a(1, 0, 0, 0, 5, 2, 3); slot_b(1, 1, 0, 0, 0, 5, 40);
    cyc("R4 no write no dependency", 2, 1, 1, 0);
  endtask

  task automatic t_fp_hold();
    drain();
    slot_a(1, 1, 0, 1, 10, 40, 41); slot_b(0, 0, 0, 0, 0, 0, 0);
    cyc("R7 fp producer", 1, 1, 0, 0);
    slot_a(1, 0, 0, 0, 0, 10, 2); slot_b(1, 1, 0, 0, 0, 44, 45);
    cyc("R7 R5 hold 1", 0, 0, 0, 1);
    cyc("R7 R5 hold 2", 0, 0, 0, 1);
    cyc("R7 R6 hold 3", 0, 0, 0, 1);
    cyc("R7 released", 2, 1, 1, 0);
  endtask

  task automatic t_load_hold();
    drain();
    slot_a(1, 0, 1, 1, 12, 2, 3); slot_b(0, 0, 0, 0, 0, 0, 0);
    cyc("R8 load producer", 1, 1, 0, 0);
    slot_a(1, 1, 0, 1, 44, 12, 45);
    cyc("R8 hold 1", 0, 0, 0, 1);
    cyc("R8 released", 1, 1, 0, 0);
  endtask

  task automatic t_alu_free();
    drain();
    slot_a(1, 0, 0, 1, 14, 2, 3); slot_b(0, 0, 0, 0, 0, 0, 0);
    cyc("R9 alu producer", 1, 1, 0, 0);
    slot_a(1, 1, 0, 0, 0, 14, 40);
    cyc("R9 reader next cycle", 1, 1, 0, 0);
  endtask

  task automatic t_young_busy();
    drain();
    slot_a(1, 1, 0, 1, 20, 40, 41); slot_b(0, 0, 0, 0, 0, 0, 0);
    cyc("R10 fp producer", 1, 1, 0, 0);
    slot_a(1, 0, 0, 0, 0, 2, 3); slot_b(1, 1, 0, 0, 0, 42, 20);
    cyc("R10 younger busy", 1, 1, 0, 0);
  endtask

  task automatic t_invalid_old();
    drain();
    slot_a(0, 0, 0, 0, 0, 2, 3); slot_b(1, 1, 0, 0, 0, 40, 41);
    cyc("R6 older invalid", 0, 0, 0, 0);
  endtask

  task automatic t_same_dst();
    drain();
    slot_a(1, 0, 1, 1, 22, 2, 3); slot_b(1, 1, 0, 1, 22, 40, 41);
    cyc("R12 load+fp same dst", 2, 1, 1, 0);
    slot_a(1, 0, 0, 0, 0, 22, 4); slot_b(0, 0, 0, 0, 0, 0, 0);
    cyc("R12 fp latency wins 1", 0, 0, 0, 1);
    cyc("R12 fp latency wins 2", 0, 0, 0, 1);
    cyc("R12 fp latency wins 3", 0, 0, 0, 1);
    cyc("R12 released", 1, 1, 0, 0);
    drain();
    slot_a(1, 1, 0, 1, 23, 40, 41); slot_b(1, 0, 0, 1, 23, 2, 3);
    cyc("R12 fp+alu same dst", 2, 1, 1, 0);
    slot_a(1, 0, 0, 0, 0, 23, 4);
    cyc("R12 alu latency wins", 1, 1, 0, 0);
  endtask

  initial begin
    t_reset();
    t_pairs();
    t_same_class();
    t_dep();
    t_fp_hold();
    t_load_hold();
    t_alu_free();
    t_young_busy();
    t_invalid_old();
    t_same_dst();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule